// File: doc/BRIEF.md
# Input Change Notifier

This block watches a bank of up to 21 general-purpose input pins and raises one sticky interrupt flag when any pin that software has armed changes level, whether it rises or falls. Each pin has an arm bit and a weak pull-up request bit. The pins are split across a low word and a high word, so the arm bits sit in two registers and the pull-up bits sit in two more. A snapshot register keeps the pin levels that software last read. Every cycle the block compares the synchronized pin levels with that snapshot.

Software reads the synchronized pin levels with a read strobe, and that strobe also reloads the snapshot. Software then clears the flag. While the system sleeps with its clock stopped, a purely combinational path compares the raw pins with the held snapshot and raises a wake request, so a change on an armed pin can still bring the system back. The pull-up requests go to the pad model through a gate that forces them off on any pin that is currently driven as an output.

Top module: `pin_change_notifier`

## Requirements
- R1: After reset, all arm bits and all pull-up bits are 0, irqFlag is 0, pullupEn is all zeros, and the snapshot holds all zeros.
- R2: A write with regWe at regAddr 0 loads the arm bits of pins 15..0 from regWdata[15:0]. Address 1 loads the arm bits of pins 20..16 from regWdata[4:0]. Address 2 loads the pull-up bits of pins 15..0, and address 3 loads the pull-up bits of pins 20..16. regRdata combinationally returns the register selected by regAddr, and bits above pin 20 in the high words read as 0.
- R3: When an armed pin moves from the snapshot level, in either direction, irqFlag rises on the third rising clock edge after pinIn changes: two synchronizer edges and then one flag edge. It is still low after the second edge.
- R4: A level change on a pin whose arm bit is 0 never sets irqFlag.
- R5: irqFlag stays high until flagClr is sampled high while no armed pin differs from the snapshot. If a mismatch is present in the same cycle as flagClr, the flag stays set.
- R6: A portRd pulse loads the snapshot from the synchronized pin levels, and portData always shows those synchronized levels.
- R7: While sleepMode is high, wakeOut is high without any clock edge exactly when some armed raw pin differs from the snapshot. While sleepMode is low, wakeOut is 0.
- R8: pullupEn[i] equals pull-up bit i AND NOT pinIsOutput[i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; may be stopped during sleep |
| rstN | input | 1 | Active-low asynchronous reset |
| pinIn | input | 21 | Raw pin levels from the pads |
| pinIsOutput | input | 21 | 1 where the pin is configured as a digital output |
| sleepMode | input | 1 | High while the system sleeps |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0/1 arm low/high, 2/3 pull-up low/high |
| regWdata | input | 16 | Register write data |
| regRdata | output | 16 | Readback of the selected register |
| portRd | input | 1 | Port read strobe; reloads the snapshot |
| portData | output | 21 | Synchronized pin levels |
| flagClr | input | 1 | Interrupt flag clear request |
| irqFlag | output | 1 | Sticky change interrupt flag |
| wakeOut | output | 1 | Clockless wake request during sleep |
| pullupEn | output | 21 | Gated weak pull-up enables to the pad model |

## Verification
The assertions assume that the control strobes (regWe, portRd, flagClr) are clean and synchronous to clk, and that pinIn is the only input allowed to move without reference to the clock. The stimulus therefore changes every strobe and pin on the falling edge. It holds each pin change for at least three edges before it reads the port or clears the flag, so the synchronizer has settled before the snapshot is taken. The clock is stopped only while the clockless wake path is being exercised, and the bench restarts it before any further register traffic.

// File: rtl/cn_pkg.sv
package cn_pkg;
  typedef enum logic [1:0] {
    ADDR_EN_LO = 2'd0,
    ADDR_EN_HI = 2'd1,
    ADDR_PU_LO = 2'd2,
    ADDR_PU_HI = 2'd3
  } cnAddr_e;

  typedef struct packed {
    logic wrEnLo;
    logic wrEnHi;
    logic wrPuLo;
    logic wrPuHi;
    logic snapLoad;
  } cnStrobes_t;
endpackage

// File: rtl/cn_datapath.sv
module cn_datapath
  import cn_pkg::*;
#(
  parameter int NUM_PINS    = 21,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIsOutput,
  input  logic                sleepMode,
  input  logic [1:0]          regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  input  cnStrobes_t          strobes,
  output logic [WORD_W-1:0]   regRdata,
  output logic [NUM_PINS-1:0] portData,
  output logic [NUM_PINS-1:0] pullupEn,
  output logic                wakeOut,
  output logic                anyChange,
  output logic [NUM_PINS-1:0] enVec,
  output logic [NUM_PINS-1:0] puVec
);
  localparam int HI_W  = NUM_PINS - WORD_W;
  localparam int PAD_W = WORD_W - HI_W;

  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] pinSync;
  logic [NUM_PINS-1:0] snapshot;

  // Synchronizer chain, one register per stage
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncChain[s] <= '0;
        else       syncChain[s] <= syncChain[s-1];
      end
    end
  end
  assign pinSync  = syncChain[SYNC_STAGES-1];
  assign portData = pinSync;

  // Configuration registers, split across a low and a high word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enVec <= '0;
      puVec <= '0;
    end else begin
      if (strobes.wrEnLo) enVec[WORD_W-1:0]        <= regWdata;
      if (strobes.wrEnHi) enVec[NUM_PINS-1:WORD_W] <= regWdata[HI_W-1:0];
      if (strobes.wrPuLo) puVec[WORD_W-1:0]        <= regWdata;
      if (strobes.wrPuHi) puVec[NUM_PINS-1:WORD_W] <= regWdata[HI_W-1:0];
    end
  end

  // Snapshot of the last levels that software read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 snapshot <= '0;
    else if (strobes.snapLoad) snapshot <= pinSync;
  end

  // Clocked compare and clockless wake compare
  assign anyChange = |((pinSync ^ snapshot) & enVec);
  assign wakeOut   = sleepMode & (|((pinIn ^ snapshot) & enVec));

  // Pull-up gating, one gate per pin
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pull
    assign pullupEn[p] = puVec[p] & ~pinIsOutput[p];
  end

  // Register readback
  always_comb begin
    unique case (cnAddr_e'(regAddr))
      ADDR_EN_LO: regRdata = enVec[WORD_W-1:0];
      ADDR_EN_HI: regRdata = {{PAD_W{1'b0}}, enVec[NUM_PINS-1:WORD_W]};
      ADDR_PU_LO: regRdata = puVec[WORD_W-1:0];
      default:    regRdata = {{PAD_W{1'b0}}, puVec[NUM_PINS-1:WORD_W]};
    endcase
  end
endmodule

// File: rtl/cn_ctrl.sv
module cn_ctrl
  import cn_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [1:0] regAddr,
  input  logic       portRd,
  input  logic       flagClr,
  input  logic       anyChange,
  output cnStrobes_t strobes,
  output logic       irqFlag
);
  always_comb begin
    strobes          = '0;
    strobes.snapLoad = portRd;
    if (regWe) begin
      unique case (cnAddr_e'(regAddr))
        ADDR_EN_LO: strobes.wrEnLo = 1'b1;
        ADDR_EN_HI: strobes.wrEnHi = 1'b1;
        ADDR_PU_LO: strobes.wrPuLo = 1'b1;
        default:    strobes.wrPuHi = 1'b1;
      endcase
    end
  end

  // Sticky flag: a mismatch wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          irqFlag <= 1'b0;
    else if (anyChange) irqFlag <= 1'b1;
    else if (flagClr)   irqFlag <= 1'b0;
  end
endmodule

// File: rtl/pin_change_notifier.sv
module pin_change_notifier
  import cn_pkg::*;
#(
  parameter int NUM_PINS    = 21,
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] pinIsOutput,
  input  logic                sleepMode,
  input  logic                regWe,
  input  logic [1:0]          regAddr,
  input  logic [WORD_W-1:0]   regWdata,
  output logic [WORD_W-1:0]   regRdata,
  input  logic                portRd,
  output logic [NUM_PINS-1:0] portData,
  input  logic                flagClr,
  output logic                irqFlag,
  output logic                wakeOut,
  output logic [NUM_PINS-1:0] pullupEn
);
  cnStrobes_t          strobes;
  logic                anyChange;
  logic [NUM_PINS-1:0] enVec;
  logic [NUM_PINS-1:0] puVec;

  cn_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .portRd   (portRd),
    .flagClr  (flagClr),
    .anyChange(anyChange),
    .strobes  (strobes),
    .irqFlag  (irqFlag)
  );

  cn_datapath #(
    .NUM_PINS   (NUM_PINS),
    .WORD_W     (WORD_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .pinIn      (pinIn),
    .pinIsOutput(pinIsOutput),
    .sleepMode  (sleepMode),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .strobes    (strobes),
    .regRdata   (regRdata),
    .portData   (portData),
    .pullupEn   (pullupEn),
    .wakeOut    (wakeOut),
    .anyChange  (anyChange),
    .enVec      (enVec),
    .puVec      (puVec)
  );
endmodule

// File: rtl/pin_change_notifier_chk.sv
module pin_change_notifier_chk #(
  parameter int NUM_PINS = 21,
  parameter int WORD_W   = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [NUM_PINS-1:0] pinIsOutput,
  input logic                sleepMode,
  input logic                regWe,
  input logic [1:0]          regAddr,
  input logic [WORD_W-1:0]   regWdata,
  input logic                flagClr,
  input logic                irqFlag,
  input logic                wakeOut,
  input logic [NUM_PINS-1:0] pullupEn,
  input logic [NUM_PINS-1:0] enVec,
  input logic [NUM_PINS-1:0] puVec
);
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (enVec == '0 && puVec == '0 && !irqFlag)); // R1

  AST_EN_LO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr == 2'd0) |=> enVec[WORD_W-1:0] == $past(regWdata)); // R2

  AST_NO_FLAG_UNARMED: assert property (@(posedge clk) disable iff (!rstN)
    (enVec == '0 && !irqFlag) |=> !irqFlag); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag); // R5

  AST_WAKE_AWAKE: assert property (@(posedge clk) disable iff (!rstN)
    !sleepMode |-> !wakeOut); // R7

  AST_PULLUP_GATED: assert property (@(posedge clk) disable iff (!rstN)
    ((pullupEn & pinIsOutput) == '0) && ((pullupEn & ~puVec) == '0)); // R8
endmodule

bind pin_change_notifier pin_change_notifier_chk #(
  .NUM_PINS(NUM_PINS),
  .WORD_W  (WORD_W)
) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .pinIsOutput(pinIsOutput),
  .sleepMode  (sleepMode),
  .regWe      (regWe),
  .regAddr    (regAddr),
  .regWdata   (regWdata),
  .flagClr    (flagClr),
  .irqFlag    (irqFlag),
  .wakeOut    (wakeOut),
  .pullupEn   (pullupEn),
  .enVec      (enVec),
  .puVec      (puVec)
);

// File: tb/pin_change_notifier_tb_top.sv
`timescale 1ns/1ps
module pin_change_notifier_tb_top;
  localparam int NP = 21;
  localparam int WW = 16;

  logic          clk = 1'b0;
  logic          clkEn = 1'b1;
  logic          rstN = 1'b0;
  logic [NP-1:0] pins = '0;
  logic [NP-1:0] isOut = '0;
  logic          sleepMode = 1'b0;
  logic          regWe = 1'b0;
  logic [1:0]    regAddr = 2'd0;
  logic [WW-1:0] regWdata = '0;
  logic [WW-1:0] regRdata;
  logic          portRd = 1'b0;
  logic [NP-1:0] portData;
  logic          flagClr = 1'b0;
  logic          irqFlag;
  logic          wakeOut;
  logic [NP-1:0] pullupEn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  pin_change_notifier dut_i (
    .clk(clk), .rstN(rstN), .pinIn(pins), .pinIsOutput(isOut),
    .sleepMode(sleepMode), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .portRd(portRd),
    .portData(portData), .flagClr(flagClr), .irqFlag(irqFlag),
    .wakeOut(wakeOut), .pullupEn(pullupEn)
  );

  // 125 MHz clock that can be stopped
  initial forever begin
    #4;
    if (clkEn) clk = ~clk;
  end

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_500_000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finishRun();
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [WW-1:0] d);
    regWe = 1'b1; regAddr = a; regWdata = d;
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic setArm(input logic [NP-1:0] en);
    writeReg(2'd0, en[WW-1:0]);
    writeReg(2'd1, {{(2*WW-NP){1'b0}}, en[NP-1:WW]});
  endtask

  // Let the pins settle, read the port, then clear the flag
  task automatic settle();
    tick(3);
    portRd = 1'b1; tick(1); portRd = 1'b0;
    flagClr = 1'b1; tick(1); flagClr = 1'b0;
  endtask

  initial begin
    #20;
    @(negedge clk);
    // R1 reset state
    check(irqFlag == 1'b0, "R1 flag", {31'd0, irqFlag}, 32'd0);
    check(pullupEn == '0, "R1 pullupEn", {11'd0, pullupEn}, 32'd0);
    for (int a = 0; a < 4; a++) begin
      regAddr = 2'(a); #1;
      check(regRdata == '0, "R1 register", {16'd0, regRdata}, 32'd0);
    end
    rstN = 1'b1;
    tick(2);

    // R2 readback and unused high bits
    writeReg(2'd0, 16'hA5C3); writeReg(2'd1, 16'hFFFF);
    writeReg(2'd2, 16'h3C5A); writeReg(2'd3, 16'hFFEA);
    regAddr = 2'd0; #1; check(regRdata == 16'hA5C3, "R2 armLo", {16'd0, regRdata}, 32'hA5C3);
    regAddr = 2'd1; #1; check(regRdata == 16'h001F, "R2 armHi", {16'd0, regRdata}, 32'h001F);
    regAddr = 2'd2; #1; check(regRdata == 16'h3C5A, "R2 puLo", {16'd0, regRdata}, 32'h3C5A);
    regAddr = 2'd3; #1; check(regRdata == 16'h000A, "R2 puHi", {16'd0, regRdata}, 32'h000A);

    // R8 pull-up gating sweep
    writeReg(2'd2, 16'hFFFF); writeReg(2'd3, 16'h001F);
    for (int p = 0; p < NP; p++) begin
      logic [NP-1:0] oh;
      oh = NP'(1) << p;
      isOut = oh; #1;
      check(pullupEn == ~oh, "R8 gate", {11'd0, pullupEn}, {11'd0, ~oh});
    end
    writeReg(2'd2, 16'h5555); writeReg(2'd3, 16'h0015);
    isOut = 21'h0F0F0; #1;
    check(pullupEn == (21'h155555 & ~21'h0F0F0), "R8 pattern",
          {11'd0, pullupEn}, {11'd0, 21'h155555 & ~21'h0F0F0});
    isOut = '0;
    settle();

    // R3 R5 R6 armed pin sweep, both directions
    for (int p = 0; p < NP; p++) begin
      setArm(NP'(1) << p);
      settle();
      for (int d = 0; d < 2; d++) begin
        pins[p] = ~pins[p];
        tick(2);
        check(irqFlag == 1'b0, "R3 early", {31'd0, irqFlag}, 32'd0);
        tick(1);
        check(irqFlag == 1'b1, "R3 set", {31'd0, irqFlag}, 32'd1);
        flagClr = 1'b1; tick(1); flagClr = 1'b0;
        check(irqFlag == 1'b1, "R5 clear blocked", {31'd0, irqFlag}, 32'd1);
        tick(2);
        check(irqFlag == 1'b1, "R5 sticky", {31'd0, irqFlag}, 32'd1);
        check(portData == pins, "R6 portData", {11'd0, portData}, {11'd0, pins});
        portRd = 1'b1; tick(1); portRd = 1'b0;
        flagClr = 1'b1; tick(1); flagClr = 1'b0;
        check(irqFlag == 1'b0, "R6 snapshot reload", {31'd0, irqFlag}, 32'd0);
      end
    end

    // R4 unarmed pin sweep
    for (int p = 0; p < NP; p++) begin
      setArm(~(NP'(1) << p));
      settle();
      pins[p] = ~pins[p];
      tick(4);
      check(irqFlag == 1'b0, "R4 unarmed", {31'd0, irqFlag}, 32'd0);
      pins[p] = ~pins[p];
      tick(4);
    end

    // R7 clockless wake
    for (int p = 0; p < NP; p += 5) begin
      setArm(NP'(1) << p);
      settle();
      pins[p] = ~pins[p]; #1;
      check(wakeOut == 1'b0, "R7 awake", {31'd0, wakeOut}, 32'd0);
      pins[p] = ~pins[p];
      clkEn = 1'b0; sleepMode = 1'b1; #20;
      check(wakeOut == 1'b0, "R7 quiet", {31'd0, wakeOut}, 32'd0);
      pins[(p + 1) % NP] = ~pins[(p + 1) % NP]; #20;
      check(wakeOut == 1'b0, "R7 unarmed", {31'd0, wakeOut}, 32'd0);
      pins[p] = ~pins[p]; #20;
      check(wakeOut == 1'b1, "R7 wake", {31'd0, wakeOut}, 32'd1);
      pins[p] = ~pins[p]; #20;
      check(wakeOut == 1'b0, "R7 revert", {31'd0, wakeOut}, 32'd0);
      sleepMode = 1'b0; clkEn = 1'b1;
      @(negedge clk);
      settle();
    end

    finishRun();
  end
endmodule